// File: doc/BRIEF.md
# Operand Hazard Detection and Forwarding Unit

This unit sits beside the decode stage of an in-order five-stage pipeline. Each cycle it takes the two source register numbers of the instruction in decode. It compares them with the destination registers of the instructions now in the execute, memory and write-back stages. Each of those destinations counts only while its stage's write enable is set. From the comparisons it flags a read-after-write dependence. It also chooses, for each operand, where the execute-stage operand mux should take its value from.

The chosen select codes are captured into the decode-to-execute pipeline register. They therefore reach the operand muxes in the same cycle as the instruction that needs them. The register file commits writes in the first half of a cycle and serves reads in the second half. For that reason a producer in write-back needs no bypass path, and its operand is read straight from the file. A load in execute whose result the decode instruction needs has not read memory yet, so it cannot be forwarded in time. In that case the unit raises a stall for one cycle. The stall holds the program counter and the fetch-to-decode register, and it turns the captured selects into a bubble.

Top module: `hzf_fwd_unit`

## Requirements
- R1: `raw_hazard` is high, combinationally, when either source matches the destination of any of the execute, memory or write-back stages whose write enable is high. This covers six comparisons in all.
- R2: Register number 0 never matches. With a source of 0, or a destination of 0, no hazard, no stall and no forwarding result.
- R3: Each operand select is 2 bits: 00 = register file, 01 = execute/memory register, 10 = memory/write-back register. The select computed in decode appears on `fwd_rs_q` / `fwd_rt_q` after the next rising clock edge.
- R4: A matching non-load producer in execute gives select 01 for that operand.
- R5: A matching producer in memory, with no match in execute, gives select 10.
- R6: A producer that matches only in write-back gives select 00, while `raw_hazard` is still high.
- R7: When execute and memory both match one operand, the execute producer (the nearest) wins, with select 01.
- R8: A matching load in execute (`ex_load`=1, `ex_wen`=1) drives `load_stall` high combinationally. On the following edge both registered selects become 00 (a bubble), even when another stage also matches.
- R9: Once the load has moved to memory and execute holds the bubble, the stall drops and the dependent operand gets select 10. The stall therefore lasts exactly one cycle.
- R10: A stage whose write enable is low never matches, even when its destination equals a source.
- R11: While `rst_n` is low, both registered selects are 00.
- R12: The two operands are resolved on their own, so rs and rt can take different selects in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | AW | First source register of the decode instruction |
| id_rt | input | AW | Second source register of the decode instruction |
| ex_rd | input | AW | Destination in execute |
| ex_wen | input | 1 | Execute stage will write its destination |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination in memory stage |
| mem_wen | input | 1 | Memory stage will write its destination |
| wb_rd | input | AW | Destination in write-back |
| wb_wen | input | 1 | Write-back stage will write its destination |
| raw_hazard | output | 1 | Any qualified source/destination match |
| load_stall | output | 1 | Hold PC and fetch/decode, bubble decode/execute |
| fwd_rs_q | output | 2 | Registered operand select for rs |
| fwd_rt_q | output | 2 | Registered operand select for rt |

## Verification
The bench builds cases where several stages name the same register. A unit that ignored distance would pick the older memory value over the execute value. It drives write-back-only matches; a unit with a needless write-back bypass would return a nonzero select there. It uses register 0 and disabled stages; a unit without qualification would forward junk or stall for nothing. It also walks a load-use pair over two cycles. Missing bubble logic would leave a stale select behind, and a stall that failed to drop would freeze the pipeline.

// File: rtl/hzf_pkg.sv
package hzf_pkg;
  localparam int NSTG = 3;
  localparam int STG_EX = 0;
  localparam int STG_MEM = 1;
  localparam int STG_WB = 2;
  localparam int NSRC = 2;

  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_EXMEM = 2'b01,
    SRC_MEMWB = 2'b10
  } src_sel_e;

  // nearest producer first; a load in execute gives no usable value yet
  function automatic src_sel_e pick_src(input logic hit_ex, input logic ex_load,
                                        input logic hit_mem);
    if (hit_ex) return ex_load ? SRC_RF : SRC_EXMEM;
    if (hit_mem) return SRC_MEMWB;
    return SRC_RF;
  endfunction

  function automatic logic needs_stall(input logic hit_ex, input logic ex_load);
    return hit_ex && ex_load;
  endfunction
endpackage

// File: rtl/hzf_stage_cmp.sv
module hzf_stage_cmp #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wen,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;
  assign hit = wen && (dst != ZERO_REG) && (src == dst);
endmodule

// File: rtl/hzf_operand.sv
module hzf_operand
  import hzf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0]            src,
  input  logic [NSTG-1:0][AW-1:0]  dst,
  input  logic [NSTG-1:0]          wen,
  input  logic                     ex_load,
  output src_sel_e                 sel,
  output logic                     hazard,
  output logic                     stall
);
  logic [NSTG-1:0] hit;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    hzf_stage_cmp #(.AW(AW)) u_cmp (
      .src(src),
      .dst(dst[s]),
      .wen(wen[s]),
      .hit(hit[s])
    );
  end

  assign hazard = |hit;
  assign stall  = needs_stall(hit[STG_EX], ex_load);
  assign sel    = pick_src(hit[STG_EX], ex_load, hit[STG_MEM]);
endmodule

// File: rtl/hzf_fwd_unit.sv
module hzf_fwd_unit
  import hzf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic          raw_hazard,
  output logic          load_stall,
  output logic [1:0]    fwd_rs_q,
  output logic [1:0]    fwd_rt_q
);
  logic [NSTG-1:0][AW-1:0] dst_vec;
  logic [NSTG-1:0]         wen_vec;
  logic [NSRC-1:0][AW-1:0] src_vec;
  src_sel_e                sel_d [NSRC];
  logic [NSRC-1:0]         op_haz;
  logic [NSRC-1:0]         op_stall;

  assign dst_vec[STG_EX]  = ex_rd;
  assign dst_vec[STG_MEM] = mem_rd;
  assign dst_vec[STG_WB]  = wb_rd;
  assign wen_vec[STG_EX]  = ex_wen;
  assign wen_vec[STG_MEM] = mem_wen;
  assign wen_vec[STG_WB]  = wb_wen;
  assign src_vec[0] = id_rs;
  assign src_vec[1] = id_rt;

  for (genvar o = 0; o < NSRC; o++) begin : g_op
    hzf_operand #(.AW(AW)) u_op (
      .src(src_vec[o]),
      .dst(dst_vec),
      .wen(wen_vec),
      .ex_load(ex_load),
      .sel(sel_d[o]),
      .hazard(op_haz[o]),
      .stall(op_stall[o])
    );
  end

  assign raw_hazard = |op_haz;
  assign load_stall = |op_stall;

  // decode/execute capture of the selects; a stall loads a bubble
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_rs_q <= SRC_RF;
      fwd_rt_q <= SRC_RF;
    end else if (load_stall) begin
      fwd_rs_q <= SRC_RF;
      fwd_rt_q <= SRC_RF;
    end else begin
      fwd_rs_q <= sel_d[0];
      fwd_rt_q <= sel_d[1];
    end
  end
endmodule

// File: rtl/hzf_fwd_chk.sv
module hzf_fwd_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] id_rs,
  input logic [AW-1:0] id_rt,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          raw_hazard,
  input logic          load_stall,
  input logic [1:0]    fwd_rs_q,
  input logic [1:0]    fwd_rt_q
);
  localparam logic [AW-1:0] Z = '0;
  logic rs_ex_alu;
  logic rs_mem_only;
  assign rs_ex_alu   = ex_wen && !ex_load && ex_rd != Z && id_rs == ex_rd;
  assign rs_mem_only = mem_wen && mem_rd != Z && id_rs == mem_rd &&
                       !(ex_wen && ex_rd != Z && id_rs == ex_rd);

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_stall |-> (ex_load && ex_wen)); // R8
  AST_STALL_IS_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
    load_stall |-> raw_hazard); // R1
  AST_BUBBLE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    load_stall |=> (fwd_rs_q == 2'b00 && fwd_rt_q == 2'b00)); // R8
  AST_ZERO_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == Z && id_rt == Z) |-> (!raw_hazard && !load_stall)); // R2
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_rs_q != 2'b11 && fwd_rt_q != 2'b11)); // R3
  AST_EX_NEAREST: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_ex_alu && !load_stall) |=> fwd_rs_q == 2'b01); // R7
  AST_MEM_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_mem_only && !load_stall) |=> fwd_rs_q == 2'b10); // R5
endmodule

bind hzf_fwd_unit hzf_fwd_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
  .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
  .mem_rd(mem_rd), .mem_wen(mem_wen),
  .raw_hazard(raw_hazard), .load_stall(load_stall),
  .fwd_rs_q(fwd_rs_q), .fwd_rt_q(fwd_rt_q)
);

// File: tb/sim_hzf_fwd_unit.sv
module sim_hzf_fwd_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] id_rs = '0, id_rt = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic       ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
  logic       raw_hazard, load_stall;
  logic [1:0] fwd_rs_q, fwd_rt_q;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hzf_fwd_unit #(.AW(5)) u0 (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .raw_hazard(raw_hazard), .load_stall(load_stall),
    .fwd_rs_q(fwd_rs_q), .fwd_rt_q(fwd_rt_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive at falling edge; settle before combinational checks
  task automatic drive(input logic [4:0] rs, input logic [4:0] rt,
                       input logic [4:0] er, input logic ew, input logic el,
                       input logic [4:0] mr, input logic mw,
                       input logic [4:0] wr, input logic ww);
    @(negedge clk);
    id_rs = rs; id_rt = rt; ex_rd = er; ex_wen = ew; ex_load = el;
    mem_rd = mr; mem_wen = mw; wb_rd = wr; wb_wen = ww;
    #1;
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    chk("R11", "rs sel in reset", fwd_rs_q, 0);
    chk("R11", "rt sel in reset", fwd_rt_q, 0);
  endtask

  task automatic t_ex_fwd();
    drive(5'd3, 5'd12, 5'd3, 1, 0, 5'd20, 1, 5'd21, 1);
    chk("R1", "hazard ex match", raw_hazard, 1);
    chk("R4", "no stall alu", load_stall, 0);
    edge_then_sample();
    chk("R4", "rs sel ex", fwd_rs_q, 1);
    chk("R3", "rt sel rf", fwd_rt_q, 0);
  endtask

  task automatic t_mem_fwd();
    drive(5'd1, 5'd7, 5'd9, 1, 0, 5'd7, 1, 5'd0, 0);
    edge_then_sample();
    chk("R5", "rt sel mem", fwd_rt_q, 2);
    chk("R5", "rs sel rf", fwd_rs_q, 0);
  endtask

  task automatic t_wb_only();
    drive(5'd9, 5'd4, 5'd0, 0, 0, 5'd0, 0, 5'd9, 1);
    chk("R1", "hazard wb match", raw_hazard, 1);
    chk("R6", "no stall wb", load_stall, 0);
    edge_then_sample();
    chk("R6", "rs sel wb only", fwd_rs_q, 0);
  endtask

  task automatic t_nearest();
    drive(5'd4, 5'd4, 5'd4, 1, 0, 5'd4, 1, 5'd4, 1);
    edge_then_sample();
    chk("R7", "rs nearest", fwd_rs_q, 1);
    chk("R7", "rt nearest", fwd_rt_q, 1);
  endtask

  task automatic t_wen_low();
    drive(5'd5, 5'd6, 5'd5, 0, 1, 5'd6, 0, 5'd5, 0);
    chk("R10", "no hazard disabled", raw_hazard, 0);
    chk("R10", "no stall disabled load", load_stall, 0);
    edge_then_sample();
    chk("R10", "rs sel disabled", fwd_rs_q, 0);
    chk("R10", "rt sel disabled", fwd_rt_q, 0);
  endtask

  task automatic t_zero();
    drive(5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1, 5'd0, 1);
    chk("R2", "no hazard r0", raw_hazard, 0);
    chk("R2", "no stall r0 load", load_stall, 0);
    edge_then_sample();
    chk("R2", "rs sel r0", fwd_rs_q, 0);
    chk("R2", "rt sel r0", fwd_rt_q, 0);
  endtask

  task automatic t_load_use();
    drive(5'd11, 5'd4, 5'd2, 1, 0, 5'd0, 0, 5'd0, 0);
    edge_then_sample();
    chk("R4", "pre-load rs sel", fwd_rs_q, 0);
    // load writing r6 in execute; rs matches memory, rt needs the load
    drive(5'd11, 5'd6, 5'd6, 1, 1, 5'd11, 1, 5'd0, 0);
    chk("R8", "stall on load use", load_stall, 1);
    chk("R1", "hazard on load use", raw_hazard, 1);
    edge_then_sample();
    chk("R8", "bubble rs", fwd_rs_q, 0);
    chk("R8", "bubble rt", fwd_rt_q, 0);
    // load moved to memory, bubble in execute
    drive(5'd11, 5'd6, 5'd6, 0, 0, 5'd6, 1, 5'd11, 1);
    chk("R9", "stall released", load_stall, 0);
    edge_then_sample();
    chk("R9", "rt sel load result", fwd_rt_q, 2);
    chk("R9", "rs sel wb only", fwd_rs_q, 0);
  endtask

  task automatic t_split();
    drive(5'd2, 5'd8, 5'd2, 1, 0, 5'd8, 1, 5'd0, 0);
    edge_then_sample();
    chk("R12", "rs from ex", fwd_rs_q, 1);
    chk("R12", "rt from mem", fwd_rt_q, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_ex_fwd();
    t_mem_fwd();
    t_wb_only();
    t_nearest();
    t_wen_low();
    t_zero();
    t_load_use();
    t_split();
    done = 1'b1;
  end

  initial begin : watchdog
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule